// File: doc/BRIEF.md
# Compact Genetic Algorithm Cell

This block searches for a bit string that maximizes the number of ones. It keeps no population. Instead it holds one counter per chromosome bit, and each counter is a probability expressed as a count out of a nominal population size. Each iteration draws two candidate strings from these counters with a per-bit pseudo-random source, then scores both by counting their ones. Every counter is moved one step toward the winning candidate wherever the two candidates disagree. An iteration count, called the confidence counter, advances on every update. The cell publishes its vector and that counter after each update, so a coordinating leader cell can watch its progress.

A leader may push a replacement vector into the cell at any time while the cell runs. The cell adopts that vector at the boundary between iterations. The search stops when every counter has reached either end of its range. The cell then raises `done` and presents the converged string on `solution`. A run begins with a `start` pulse, which also loads the seed of the random source, so two runs with the same seed follow the same trajectory.

Top module: `cga_cell`

## Requirements
- R1: After reset `done` and `pub_valid` are 0, `pub_cc` is 0 and every entry of `pub_pv` equals POP/2. Entry i occupies bits [i*PV_W +: PV_W], where PV_W = log2(POP)+1.
- R2: One iteration takes four clock cycles. The first `pub_valid` pulse comes on the third rising edge after the edge that samples `start`. Later pulses follow every four cycles while the cell runs, and each pulse is one cycle wide.
- R3: `start` clears the confidence counter. Every `pub_valid` pulse shows `pub_cc` one greater than at the previous pulse, so the first pulse shows 1.
- R4: Between consecutive publications each entry changes by at most 1 and always stays within 0..POP.
- R5: Without a load, the number of entries that rose in an iteration is at least the number that fell. The candidate with more ones wins, and a tie goes to the first candidate.
- R6: Without a load, an entry at 0 or at POP never changes.
- R7: `done` rises one cycle after the publication whose entries are all 0 or POP. `solution` bit i is 1 exactly when entry i equals POP. `done` holds and `pub_valid` stays 0 until the next `start`.
- R8: A `load` pulse while running replaces the vector at the end of the current iteration, including when it arrives in that iteration's last cycle. The next publication lies within 1 of the loaded values in every entry, and `pub_cc` keeps counting.
- R9: A `load` while the cell is idle has no effect. `pub_pv` stays unchanged, and the next run starts from POP/2.
- R10: Two runs with the same seed publish the same number of iterations and end with the same solution.
- R11: Loading a vector whose entries are all 0 or POP ends the run after exactly one further iteration, with `solution` equal to the loaded pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new run: vector to POP/2, counter to 0, reseed |
| seed | input | 32 | Seed for the per-bit random sources, taken on `start` |
| load | input | 1 | Offer of a replacement vector from the leader |
| load_pv | input | CHROM_W*PV_W | Replacement vector, values above POP are clamped |
| pub_valid | output | 1 | One-cycle strobe: vector and counter were just updated |
| pub_pv | output | CHROM_W*PV_W | Current probability vector |
| pub_cc | output | CC_W | Confidence counter |
| done | output | 1 | Vector has converged, run finished |
| solution | output | CHROM_W | Converged bit string |

## Verification
The hardest state to reach is the iteration boundary in which a replacement vector arrives. The load must land both in the middle of an iteration and in its closing cycle, and the bench must still know which reference the next publication is measured against. The bench waits for a publication strobe and drives `load` in that same cycle. The strobe cycle is the last cycle of the iteration, so the replacement takes the direct path rather than the pending register. The bench then measures the following publication against the loaded values instead of the previous vector. A fully converged replacement additionally fixes the exact iteration in which `done` must rise.

// File: rtl/cga_pkg.sv
package cga_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE_A,
        PH_SAMPLE_B,
        PH_UPDATE,
        PH_CHECK
    } phase_e;

    // Control broadcast from the sequencer to every vector lane.
    typedef struct packed {
        logic init;      // new run: reset entry, reseed random source
        logic step_a;    // draw bit of the first candidate
        logic step_b;    // draw bit of the second candidate
        logic update;    // move entry toward the winner
        logic win_a;     // first candidate won the fitness compare
        logic ld_en;     // take the replacement value
    } lane_ctl_t;

    localparam logic [31:0] RNG_TAPS = 32'h8020_0003;
    localparam logic [31:0] RNG_SALT = 32'h9E37_79B9;

    // Advance a right-shifting Galois shift register by n steps.
    function automatic logic [31:0] rng_advance(logic [31:0] s, int n);
        logic [31:0] r;
        r = s;
        for (int k = 0; k < 32; k++) begin
            if (k < n) r = r[0] ? ((r >> 1) ^ RNG_TAPS) : (r >> 1);
        end
        return r;
    endfunction

    // Distinct, never-zero starting state per lane.
    function automatic logic [31:0] lane_seed(logic [31:0] s, int idx);
        logic [31:0] m;
        m = s ^ (RNG_SALT * 32'(idx + 1));
        m = {m[18:0], m[31:19]} ^ 32'(idx);
        return (m == 32'h0) ? 32'h1 : m;
    endfunction

    function automatic logic [6:0] ones64(logic [63:0] v);
        logic [6:0] c;
        c = '0;
        for (int k = 0; k < 64; k++) c = c + 7'(v[k]);
        return c;
    endfunction

endpackage

// File: rtl/cga_rng.sv
module cga_rng
    import cga_pkg::*;
#(
    parameter int OUT_W = 8,
    parameter int LANE  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reseed,
    input  logic [31:0]      seed,
    output logic [OUT_W-1:0] rnd
);

    logic [31:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)         state_q <= lane_seed(32'h1, LANE);
        else if (reseed) state_q <= lane_seed(seed, LANE);
        else             state_q <= rng_advance(state_q, OUT_W);
    end

    assign rnd = state_q[OUT_W-1:0];

    // R10: the source never locks up in the all-zero state
    a_r10_rng_live: assert property (@(posedge clk) disable iff (rst)
        state_q != 32'h0);

endmodule

// File: rtl/cga_pv_lane.sv
module cga_pv_lane
    import cga_pkg::*;
#(
    parameter int POP  = 256,
    parameter int LANE = 0,
    localparam int PV_W  = $clog2(POP) + 1,
    localparam int RND_W = $clog2(POP)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     seed,
    input  lane_ctl_t       ctl,
    input  logic [PV_W-1:0] ld_val,
    output logic [PV_W-1:0] entry,
    output logic            bit_a,
    output logic            bit_b
);

    localparam logic [PV_W-1:0] P_MAX = PV_W'(POP);
    localparam logic [PV_W-1:0] P_MID = PV_W'(POP / 2);

    logic [RND_W-1:0] rnd;
    logic             draw;
    logic             win_bit;
    logic [PV_W-1:0]  entry_q;

    cga_rng #(.OUT_W(RND_W), .LANE(LANE)) u_rng (
        .clk    (clk),
        .rst    (rst),
        .reseed (ctl.init),
        .seed   (seed),
        .rnd    (rnd)
    );

    assign draw    = ({1'b0, rnd} < entry_q);
    assign win_bit = ctl.win_a ? bit_a : bit_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_a <= 1'b0;
            bit_b <= 1'b0;
        end else begin
            if (ctl.step_a) bit_a <= draw;
            if (ctl.step_b) bit_b <= draw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.init) begin
            entry_q <= P_MID;
        end else if (ctl.ld_en) begin
            entry_q <= (ld_val > P_MAX) ? P_MAX : ld_val;
        end else if (ctl.update && (bit_a != bit_b)) begin
            if (win_bit && entry_q != P_MAX)       entry_q <= entry_q + 1'b1;
            else if (!win_bit && entry_q != '0)    entry_q <= entry_q - 1'b1;
        end
    end

    assign entry = entry_q;

    // R4: entry moves by at most one per cycle outside init and load
    a_r4_unit_step: assert property (@(posedge clk) disable iff (rst)
        (!ctl.init && !ctl.ld_en) |=>
            ({1'b0, entry_q} <= {1'b0, $past(entry_q)} + 1'b1) &&
            ({1'b0, entry_q} + 1'b1 >= {1'b0, $past(entry_q)}));

    // R4: entry never exceeds the nominal population
    a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
        entry_q <= P_MAX);

    // R6: a saturated entry is frozen while no load or restart occurs
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        (!ctl.init && !ctl.ld_en && (entry_q == '0 || entry_q == P_MAX))
            |=> $stable(entry_q));

endmodule

// File: rtl/cga_cell.sv
module cga_cell
    import cga_pkg::*;
#(
    parameter int CHROM_W = 32,
    parameter int POP     = 256,
    parameter int CC_W    = 16,
    localparam int PV_W   = $clog2(POP) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [31:0]             seed,
    input  logic                    load,
    input  logic [CHROM_W*PV_W-1:0] load_pv,
    output logic                    pub_valid,
    output logic [CHROM_W*PV_W-1:0] pub_pv,
    output logic [CC_W-1:0]         pub_cc,
    output logic                    done,
    output logic [CHROM_W-1:0]      solution
);

    localparam logic [PV_W-1:0] P_MAX = PV_W'(POP);

    phase_e                  state_q;
    logic [CC_W-1:0]         cc_q;
    logic                    pend_q;
    logic [CHROM_W*PV_W-1:0] pend_pv_q;
    logic                    done_q;
    logic                    pub_q;
    logic [CHROM_W-1:0]      sol_q;

    lane_ctl_t               ctl;
    logic [CHROM_W-1:0]      ind_a, ind_b;
    logic [CHROM_W-1:0]      conv_vec, sol_now;
    logic [CHROM_W*PV_W-1:0] ld_src;
    logic [6:0]              fit_a, fit_b;
    logic                    all_conv;
    logic                    take_load;

    assign fit_a     = ones64(64'(ind_a));
    assign fit_b     = ones64(64'(ind_b));
    assign take_load = (state_q == PH_CHECK) && (load || pend_q);
    assign ld_src    = load ? load_pv : pend_pv_q;
    assign all_conv  = &conv_vec;

    always_comb begin
        ctl        = '0;
        ctl.init   = start;
        ctl.step_a = !start && (state_q == PH_SAMPLE_A);
        ctl.step_b = !start && (state_q == PH_SAMPLE_B);
        ctl.update = !start && (state_q == PH_UPDATE);
        ctl.win_a  = (fit_a >= fit_b);
        ctl.ld_en  = !start && take_load;
    end

    for (genvar i = 0; i < CHROM_W; i++) begin : g_lane
        logic [PV_W-1:0] ent;

        cga_pv_lane #(.POP(POP), .LANE(i)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .seed   (seed),
            .ctl    (ctl),
            .ld_val (ld_src[i*PV_W +: PV_W]),
            .entry  (ent),
            .bit_a  (ind_a[i]),
            .bit_b  (ind_b[i])
        );

        assign pub_pv[i*PV_W +: PV_W] = ent;
        assign conv_vec[i]            = (ent == '0) || (ent == P_MAX);
        assign sol_now[i]             = (ent == P_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PH_IDLE;
            cc_q      <= '0;
            pend_q    <= 1'b0;
            pend_pv_q <= '0;
            done_q    <= 1'b0;
            pub_q     <= 1'b0;
            sol_q     <= '0;
        end else if (start) begin
            state_q <= PH_SAMPLE_A;
            cc_q    <= '0;
            pend_q  <= 1'b0;
            done_q  <= 1'b0;
            pub_q   <= 1'b0;
            sol_q   <= '0;
        end else begin
            pub_q <= 1'b0;
            if (load && (state_q == PH_SAMPLE_A || state_q == PH_SAMPLE_B ||
                         state_q == PH_UPDATE)) begin
                pend_q    <= 1'b1;
                pend_pv_q <= load_pv;
            end
            case (state_q)
                PH_SAMPLE_A: state_q <= PH_SAMPLE_B;
                PH_SAMPLE_B: state_q <= PH_UPDATE;
                PH_UPDATE: begin
                    cc_q    <= cc_q + 1'b1;
                    pub_q   <= 1'b1;
                    state_q <= PH_CHECK;
                end
                PH_CHECK: begin
                    if (take_load) begin
                        pend_q  <= 1'b0;
                        state_q <= PH_SAMPLE_A;
                    end else if (all_conv) begin
                        done_q  <= 1'b1;
                        sol_q   <= sol_now;
                        state_q <= PH_IDLE;
                    end else begin
                        state_q <= PH_SAMPLE_A;
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    assign pub_valid = pub_q;
    assign pub_cc    = cc_q;
    assign done      = done_q;
    assign solution  = sol_q;

    // R2: a publication follows the update phase
    a_r2_pub_after_update: assert property (@(posedge clk) disable iff (rst)
        pub_valid |-> $past(state_q) == PH_UPDATE);

    // R2: the strobe is one cycle wide
    a_r2_pub_single: assert property (@(posedge clk) disable iff (rst)
        pub_valid |=> !pub_valid);

    // R3: each publication carries the counter one higher
    a_r3_cc_step: assert property (@(posedge clk) disable iff (rst)
        pub_valid |-> pub_cc == $past(pub_cc) + 1'b1);

    // R7: a finished run holds a converged vector matching the solution
    a_r7_done_converged: assert property (@(posedge clk) disable iff (rst)
        done |-> (all_conv && solution == sol_now));

    // R7: no publication after the run has ended
    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !pub_valid);

endmodule

// File: tb/cga_cell_tb_top.sv
module cga_cell_tb_top;

    localparam int CW   = 8;
    localparam int POPN = 16;
    localparam int PW   = 5;
    localparam int MID  = POPN / 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [31:0]       seed = 32'h0;
    logic              load = 1'b0;
    logic [CW*PW-1:0]  load_pv = '0;
    logic              pub_valid;
    logic [CW*PW-1:0]  pub_pv;
    logic [15:0]       pub_cc;
    logic              done;
    logic [CW-1:0]     solution;

    int n_tests = 0;
    int n_fail  = 0;
    int prev_v[CW];

    always #10 clk = ~clk;

    cga_cell #(.CHROM_W(CW), .POP(POPN), .CC_W(16)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .seed      (seed),
        .load      (load),
        .load_pv   (load_pv),
        .pub_valid (pub_valid),
        .pub_pv    (pub_pv),
        .pub_cc    (pub_cc),
        .done      (done),
        .solution  (solution)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ent(input logic [CW*PW-1:0] v, input int i);
        return int'(v[i*PW +: PW]);
    endfunction

    function automatic logic [CW*PW-1:0] pack_vec(input int e[CW]);
        logic [CW*PW-1:0] r;
        r = '0;
        for (int i = 0; i < CW; i++) r[i*PW +: PW] = PW'(e[i]);
        return r;
    endfunction

    // One run; optional load at publication number load_at.
    task automatic run(input logic [31:0] sd, input int load_at,
                       input logic [CW*PW-1:0] ldv,
                       output int iters, output logic [CW-1:0] sol);
        int  gap;
        int  exp_cc;
        int  ref_v[CW];
        bit  loaded;
        bit  fin;
        iters  = 0;
        gap    = 0;
        exp_cc = 0;
        loaded = 1'b0;
        fin    = 1'b0;
        for (int i = 0; i < CW; i++) prev_v[i] = MID;
        seed  = sd;
        start = 1'b1;
        while (!fin) begin
            @(negedge clk);
            start = 1'b0;
            load  = 1'b0;
            gap++;
            if (pub_valid) begin
                int up, dn;
                up = 0;
                dn = 0;
                exp_cc++;
                iters++;
                for (int i = 0; i < CW; i++)
                    ref_v[i] = loaded ? ent(ldv, i) : prev_v[i];
                chk(gap == 4, "R2", "cycles between publications", gap, 4);
                chk(int'(pub_cc) == exp_cc, loaded ? "R8" : "R3",
                    "confidence counter", pub_cc, exp_cc);
                for (int i = 0; i < CW; i++) begin
                    int nv, d;
                    nv = ent(pub_pv, i);
                    d  = nv - ref_v[i];
                    chk(d >= -1 && d <= 1 && nv <= POPN, loaded ? "R8" : "R4",
                        $sformatf("entry %0d", i), nv, ref_v[i]);
                    if (ref_v[i] == 0 || ref_v[i] == POPN)
                        chk(nv == ref_v[i], "R6",
                            $sformatf("saturated entry %0d", i), nv, ref_v[i]);
                    if (d > 0) up++;
                    if (d < 0) dn++;
                end
                chk(up >= dn, "R5", "rising entries minus falling", up - dn, 0);
                for (int i = 0; i < CW; i++) prev_v[i] = ent(pub_pv, i);
                loaded = 1'b0;
                gap    = 0;
                if (iters == load_at) begin
                    load    = 1'b1;
                    load_pv = ldv;
                    loaded  = 1'b1;
                end
            end
            if (done) begin
                logic [CW-1:0] exp_sol;
                bit conv;
                conv = 1'b1;
                for (int i = 0; i < CW; i++) begin
                    exp_sol[i] = (prev_v[i] == POPN);
                    if (prev_v[i] != 0 && prev_v[i] != POPN) conv = 1'b0;
                end
                chk(conv && gap == 1, "R7", "done one cycle after converged publication",
                    gap, 1);
                chk(solution == exp_sol, "R7", "solution", solution, exp_sol);
                sol = solution;
                @(negedge clk);
                chk(done && !pub_valid, "R7", "done held, strobe quiet",
                    {done, pub_valid}, 2);
                fin = 1'b1;
            end else if (iters > 4000) begin
                chk(1'b0, "R7", "run did not converge", iters, 4000);
                sol = '0;
                fin = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual hung, expected run to end");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int            it_a, it_b;
        logic [CW-1:0] s_a, s_b;
        int            ld_e[CW];
        logic [CW*PW-1:0] snap;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!done && !pub_valid, "R1", "done/pub_valid after reset",
            {done, pub_valid}, 0);
        chk(pub_cc == 0, "R1", "counter after reset", pub_cc, 0);
        for (int i = 0; i < CW; i++)
            chk(ent(pub_pv, i) == MID, "R1", $sformatf("entry %0d after reset", i),
                ent(pub_pv, i), MID);

        // Seed sweep, no loads (R2..R7)
        for (int s = 1; s <= 10; s++) begin
            int it;
            logic [CW-1:0] so;
            run(32'(s) * 32'h0101_1F3B, -1, '0, it, so);
        end

        // R10 repeatability
        run(32'hCAFE_0003, -1, '0, it_a, s_a);
        run(32'hCAFE_0003, -1, '0, it_b, s_b);
        chk(it_a == it_b, "R10", "iterations with same seed", it_b, it_a);
        chk(s_a == s_b, "R10", "solution with same seed", s_b, s_a);

        // R9 load while idle is ignored
        snap = pub_pv;
        load = 1'b1;
        for (int i = 0; i < CW; i++) ld_e[i] = (i * 3) % (POPN + 1);
        load_pv = pack_vec(ld_e);
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        chk(pub_pv == snap, "R9", "vector after idle load", pub_pv, snap);
        begin
            int it;
            logic [CW-1:0] so;
            run(32'h0000_1234, -1, '0, it, so);   // first publication is checked against MID
        end

        // R8 mid-range load in the closing cycle of an iteration
        ld_e = '{1, 15, 8, 2, 14, 7, 9, 4};
        begin
            int it;
            logic [CW-1:0] so;
            run(32'h0BAD_F00D, 3, pack_vec(ld_e), it, so);
            chk(it > 3, "R8", "run continued past load", it, 4);
        end

        // R11 converged load: pattern 8'hA6 -> entries 16 where bit set, 0 elsewhere
        for (int i = 0; i < CW; i++) ld_e[i] = ((8'hA6 >> i) & 1) != 0 ? POPN : 0;
        begin
            int it;
            logic [CW-1:0] so;
            run(32'h7777_0001, 2, pack_vec(ld_e), it, so);
            chk(it == 3, "R11", "iterations to finish after converged load", it, 3);
            chk(so == 8'hA6, "R11", "solution after converged load", so, 8'hA6);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule